// File: doc/BRIEF.md
# Compare-Match Event Timer Channel

An up-counting timer channel that produces a tick interrupt. Software selects a count clock, loads a compare value and issues a single command that enables the clock and restarts the count from zero. Each time the counter reaches the compare value, the channel sets a sticky compare flag. It drives the interrupt output when the matching mask bit is set.

In periodic mode the counter returns to zero on the match and keeps counting, so events repeat every compare+1 ticks. In one-shot mode the match also switches the channel clock off, so exactly one event occurs per start. The count clock is the system clock divided by 2, 8, 32 or 128, or an external slow-clock strobe. The counter width is a parameter (16 or 32).

Top module: `evt_timer_chan`

Register map (3-bit word address):

| Address | Name | Access | Fields |
|---|---|---|---|
| 0 | MODE | read/write | [2:0] clock select, [3] one-shot |
| 1 | CMP | read/write | compare value, CNT_W bits |
| 2 | CMD | write | [0] enable, [1] disable, [2] restart |
| 3 | IEN | write | a 1 in bit 0 sets the mask |
| 4 | IDIS | write | a 1 in bit 0 clears the mask |
| 5 | IMASK | read | [0] mask |
| 6 | STATUS | read | [0] compare flag, [1] clock running |
| 7 | COUNT | read | counter value |

## Requirements
- R1: After reset the counter is 0, the clock is stopped, STATUS and IMASK read 0 and irq_o is low.
- R2: A CMD write with bit 0 (enable) and bit 2 (restart) set clears the counter and the prescaler and starts counting. The first compare event sets the flag exactly (CMP+1)*D clock cycles after the write edge, where D is the tick period in cycles.
- R3: With MODE bit 3 clear (periodic), the counter returns to 0 on a match and continues, so the next event follows (CMP+1)*D cycles later.
- R4: With MODE bit 3 set (one-shot), a match stops the clock (STATUS bit 1 goes to 0) and leaves COUNT at 0, and no further event follows.
- R5: A match sets STATUS bit 0. irq_o is STATUS bit 0 ANDed with IMASK bit 0.
- R6: A read of STATUS returns the flag and clears it. If a match occurs in the same cycle as the read, the flag stays set.
- R7: A write to IEN with bit 0 set sets the mask, and a write to IDIS with bit 0 set (for example 0xFF) clears it. IMASK reads the mask back. Changing the mask does not change the sticky flag.
- R8: A MODE clock select of 0, 1, 2 or 3 ticks every 2, 8, 32 or 128 cycles. Select 4 ticks once per cycle in which slow_tick_i is high. Selects 5 to 7 never tick.
- R9: CMD bit 1 (disable) stops the clock and the counter holds its value. Disable wins over enable in the same write.
- R10: CMP keeps only its low CNT_W bits, so the largest delay is 2^CNT_W-1 ticks plus one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | system clock |
| rst_ni | input | 1 | active-low asynchronous reset |
| slow_tick_i | input | 1 | one-cycle strobe per slow-clock period |
| wr_en_i | input | 1 | register write strobe |
| rd_en_i | input | 1 | register read strobe (clears STATUS flag) |
| addr_i | input | 3 | register word address |
| wdata_i | input | DATA_W | write data |
| rdata_o | output | DATA_W | read data, combinational from addr_i |
| irq_o | output | 1 | interrupt request |

## Verification
The compare flag and irq_o rise on the clock edge that ends tick number CMP+1, counted from the restart write edge. The bench therefore checks irq_o low after edge (CMP+1)*D-1 and high after edge (CMP+1)*D, and again one period later for periodic mode. Register reads are combinational and are sampled in the low phase before the edge that applies the read side effect. Every check is made at the negative edge after a known number of rising edges, so the timing of each result is exact and cannot drift by a cycle.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam logic [2:0] A_MODE   = 3'd0;
  localparam logic [2:0] A_CMP    = 3'd1;
  localparam logic [2:0] A_CMD    = 3'd2;
  localparam logic [2:0] A_IEN    = 3'd3;
  localparam logic [2:0] A_IDIS   = 3'd4;
  localparam logic [2:0] A_IMASK  = 3'd5;
  localparam logic [2:0] A_STATUS = 3'd6;
  localparam logic [2:0] A_COUNT  = 3'd7;

  localparam int CMD_EN   = 0;
  localparam int CMD_DIS  = 1;
  localparam int CMD_TRIG = 2;
  localparam int MODE_OS  = 3;

  localparam logic [2:0] SEL_DIV2 = 3'd0;
  localparam logic [2:0] SEL_SLOW = 3'd4;
  localparam int         NUM_DIV  = 4;
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler
  import tmr_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clr_i,
  input  logic [2:0] sel_i,
  input  logic       slow_i,
  output logic       tick_o
);
  localparam int PRE_W = 2 * NUM_DIV - 1;

  logic [PRE_W-1:0]   pre_q;
  logic [NUM_DIV-1:0] div_tick;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pre_q <= '0;
    else if (clr_i)  pre_q <= '0;
    else             pre_q <= pre_q + {{(PRE_W-1){1'b0}}, 1'b1};
  end

  // divider k ticks every 2^(2k+1) cycles
  for (genvar k = 0; k < NUM_DIV; k++) begin : g_div
    assign div_tick[k] = &pre_q[2*k:0];
  end

  always_comb begin
    if (sel_i < SEL_SLOW)       tick_o = div_tick[sel_i[1:0]];
    else if (sel_i == SEL_SLOW) tick_o = slow_i;
    else                        tick_o = 1'b0;
  end

  AST_DIV2_ALTERNATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && sel_i == SEL_DIV2 && !clr_i) |=> (sel_i != SEL_DIV2 || !tick_o)); // R8
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             en_i,
  input  logic             dis_i,
  input  logic             trig_i,
  input  logic             one_shot_i,
  input  logic [CNT_W-1:0] cmp_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             active_o,
  output logic             match_o
);
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] cnt_q;
  logic             active_q;
  logic             hit;

  assign hit     = (cnt_q == cmp_i);
  assign match_o = active_q && tick_i && hit && !trig_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   cnt_q <= '0;
    else if (trig_i)               cnt_q <= '0;
    else if (active_q && tick_i)   cnt_q <= hit ? '0 : cnt_q + ONE;
  end

  // disable wins over enable; one-shot halts on match
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      active_q <= 1'b0;
    else if (dis_i)                   active_q <= 1'b0;
    else if (en_i)                    active_q <= 1'b1;
    else if (match_o && one_shot_i)   active_q <= 1'b0;
  end

  assign cnt_o    = cnt_q;
  assign active_o = active_q;

  AST_ONESHOT_HALT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (match_o && one_shot_i && !en_i) |=> !active_q); // R4
  AST_PERIODIC_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (match_o && !one_shot_i && !dis_i) |=> (cnt_q == '0 && active_q)); // R3
  AST_HOLD_WHEN_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!active_q && !trig_i) |=> $stable(cnt_q)); // R9
  AST_DIS_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dis_i |=> !active_q); // R9
endmodule

// File: rtl/tmr_regs.sv
module tmr_regs
  import tmr_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [2:0]        addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              active_i,
  input  logic              cmp_evt_i,
  output logic [2:0]        sel_o,
  output logic              one_shot_o,
  output logic [CNT_W-1:0]  cmp_o,
  output logic              en_o,
  output logic              dis_o,
  output logic              trig_o,
  output logic              irq_o
);
  logic [2:0]       sel_q;
  logic             os_q;
  logic [CNT_W-1:0] cmp_q;
  logic             mask_q;
  logic             sts_q;
  logic             wr_mode, wr_cmp, wr_cmd, wr_ien, wr_idis, rd_sts;

  assign wr_mode = wr_en_i && addr_i == A_MODE;
  assign wr_cmp  = wr_en_i && addr_i == A_CMP;
  assign wr_cmd  = wr_en_i && addr_i == A_CMD;
  assign wr_ien  = wr_en_i && addr_i == A_IEN;
  assign wr_idis = wr_en_i && addr_i == A_IDIS;
  assign rd_sts  = rd_en_i && addr_i == A_STATUS;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q <= '0;
      os_q  <= 1'b0;
      cmp_q <= '0;
    end else begin
      if (wr_mode) begin
        sel_q <= wdata_i[2:0];
        os_q  <= wdata_i[MODE_OS];
      end
      if (wr_cmp) cmp_q <= wdata_i[CNT_W-1:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      mask_q <= 1'b0;
    else if (wr_idis && wdata_i[0])   mask_q <= 1'b0;
    else if (wr_ien && wdata_i[0])    mask_q <= 1'b1;
  end

  // a new event beats the read-clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        sts_q <= 1'b0;
    else if (cmp_evt_i) sts_q <= 1'b1;
    else if (rd_sts)    sts_q <= 1'b0;
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      A_MODE:   begin rdata_o[2:0] = sel_q; rdata_o[MODE_OS] = os_q; end
      A_CMP:    rdata_o[CNT_W-1:0] = cmp_q;
      A_IMASK:  rdata_o[0] = mask_q;
      A_STATUS: begin rdata_o[0] = sts_q; rdata_o[1] = active_i; end
      A_COUNT:  rdata_o[CNT_W-1:0] = cnt_i;
      default:  rdata_o = '0;
    endcase
  end

  assign en_o       = wr_cmd && wdata_i[CMD_EN];
  assign dis_o      = wr_cmd && wdata_i[CMD_DIS];
  assign trig_o     = wr_cmd && wdata_i[CMD_TRIG];
  assign sel_o      = sel_q;
  assign one_shot_o = os_q;
  assign cmp_o      = cmp_q;
  assign irq_o      = sts_q && mask_q;

  logic unused_wdata;
  assign unused_wdata = ^wdata_i;

  AST_FLAG_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmp_evt_i |=> sts_q); // R5
  AST_READ_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_sts && !cmp_evt_i) |=> !sts_q); // R6
  AST_IEN_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_ien && wdata_i[0]) |=> mask_q); // R7
  AST_IDIS_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_idis && wdata_i[0]) |=> !mask_q); // R7
endmodule

// File: rtl/evt_timer_chan.sv
module evt_timer_chan #(
  parameter int CNT_W  = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              slow_tick_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [2:0]        addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  logic [2:0]       sel;
  logic             one_shot, en, dis, trig, tick, active, match;
  logic [CNT_W-1:0] cmp, cnt;

  tmr_regs #(.CNT_W(CNT_W), .DATA_W(DATA_W)) i_regs (
    .clk_i, .rst_ni, .wr_en_i, .rd_en_i, .addr_i, .wdata_i, .rdata_o,
    .cnt_i(cnt), .active_i(active), .cmp_evt_i(match),
    .sel_o(sel), .one_shot_o(one_shot), .cmp_o(cmp),
    .en_o(en), .dis_o(dis), .trig_o(trig), .irq_o
  );

  tmr_prescaler i_pre (
    .clk_i, .rst_ni, .clr_i(trig), .sel_i(sel), .slow_i(slow_tick_i), .tick_o(tick)
  );

  tmr_counter #(.CNT_W(CNT_W)) i_cnt (
    .clk_i, .rst_ni, .tick_i(tick), .en_i(en), .dis_i(dis), .trig_i(trig),
    .one_shot_i(one_shot), .cmp_i(cmp), .cnt_o(cnt), .active_o(active),
    .match_o(match)
  );

  AST_IRQ_NEEDS_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) && !$past(wr_en_i) |-> $past(active)); // R5
endmodule

// File: tb/test_evt_timer_chan.sv
`timescale 1ns/1ps
module test_evt_timer_chan;
  localparam int DW = 32;
  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          slow = 1'b0;
  logic          wr = 1'b0;
  logic          rd = 1'b0;
  logic [2:0]    addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic          irq;
  int            total = 0;
  int            bad = 0;
  bit            done = 1'b0;

  always #10 clk = ~clk;

  evt_timer_chan #(.CNT_W(16), .DATA_W(DW)) i_evt_timer_chan (
    .clk_i(clk), .rst_ni(rst_n), .slow_tick_i(slow), .wr_en_i(wr), .rd_en_i(rd),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  function automatic int div_of(int sel);
    return 2 << (2 * sel);
  endfunction

  task automatic check(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr_reg(logic [2:0] a, logic [DW-1:0] d);
    addr = a; wdata = d; wr = 1'b1;
    @(posedge clk); @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rd_reg(logic [2:0] a, output logic [DW-1:0] d);
    addr = a; rd = 1'b1; #1;
    d = rdata;
    @(posedge clk); @(negedge clk);
    rd = 1'b0;
  endtask

  task automatic cycles(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic pulse_slow();
    slow = 1'b1;
    @(posedge clk); @(negedge clk);
    slow = 1'b0;
  endtask

  task automatic prep(int mode, int cmpv);
    logic [DW-1:0] d;
    wr_reg(3'd2, 32'h2);
    rd_reg(3'd6, d);
    wr_reg(3'd0, mode);
    wr_reg(3'd1, cmpv);
    wr_reg(3'd3, 32'h1);
  endtask

  task automatic run_case(int sel, int rc, bit os);
    logic [DW-1:0] d;
    int p;
    p = (rc + 1) * div_of(sel);
    prep({os, 3'(sel)}, rc);
    wr_reg(3'd2, 32'h5);
    cycles(p - 1);
    check("R2 irq before due edge", irq, 0);
    cycles(1);
    check("R2 irq at due edge", irq, 1);
    rd_reg(3'd6, d);
    check("R5 status flag", d[0], 1);
    check("R4 run bit after match", d[1], !os);
    if (!os) begin
      if (p > 2) cycles(p - 2);
      check("R3 no early repeat", irq, 0);
      cycles(1);
      check("R3 periodic repeat", irq, 1);
      rd_reg(3'd6, d);
    end else begin
      rd_reg(3'd7, d);
      check("R4 count after one-shot", d, 0);
      cycles(2 * p);
      check("R4 no second event", irq, 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] d, c1, c2;
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1
    check("R1 irq", irq, 0);
    rd_reg(3'd7, d); check("R1 count", d, 0);
    rd_reg(3'd6, d); check("R1 status", d, 0);
    rd_reg(3'd5, d); check("R1 mask", d, 0);

    // R10
    wr_reg(3'd1, 32'h0001_2345);
    rd_reg(3'd1, d); check("R10 compare truncated", d, 32'h2345);
    wr_reg(3'd0, 32'hFFFF_FFF9);
    rd_reg(3'd0, d); check("R10 mode fields", d, 32'h9);

    // R2 R3 R4 directed
    run_case(0, 0, 1'b0);
    run_case(3, 1, 1'b1);
    run_case(1, 5, 1'b0);

    // R6 event coincides with status read
    prep(0, 0);
    wr_reg(3'd2, 32'h5);
    cycles(1);
    rd_reg(3'd6, d);
    check("R6 read before event", d[0], 0);
    check("R6 set beats clear", irq, 1);

    // R7 mask with sticky flag
    wr_reg(3'd2, 32'h2);
    wr_reg(3'd4, 32'hFF);
    check("R7 idis masks irq", irq, 0);
    rd_reg(3'd5, d); check("R7 mask cleared", d, 0);
    wr_reg(3'd3, 32'h1);
    check("R7 flag kept under mask", irq, 1);
    rd_reg(3'd5, d); check("R7 mask set", d, 1);
    rd_reg(3'd6, d);

    // R9 disable wins, count holds
    prep(0, 1000);
    wr_reg(3'd2, 32'h5);
    cycles(30);
    wr_reg(3'd2, 32'h3);
    rd_reg(3'd7, c1);
    cycles(20);
    rd_reg(3'd7, c2);
    check("R9 count held", c2, c1);
    check("R9 count advanced before stop", c1 != 0, 1);
    rd_reg(3'd6, d); check("R9 clock stopped", d[1], 0);

    // R8 slow clock strobe
    prep(4, 2);
    wr_reg(3'd2, 32'h5);
    cycles(20);
    rd_reg(3'd7, d); check("R8 slow idle no count", d, 0);
    pulse_slow(); pulse_slow();
    rd_reg(3'd7, d); check("R8 slow two ticks", d, 2);
    check("R8 no irq yet", irq, 0);
    pulse_slow();
    check("R8 slow match irq", irq, 1);
    rd_reg(3'd7, d); check("R8 wrapped", d, 0);
    prep(5, 2);
    wr_reg(3'd2, 32'h5);
    repeat (4) pulse_slow();
    cycles(10);
    rd_reg(3'd7, d); check("R8 reserved select no tick", d, 0);

    // random cases
    for (int i = 0; i < 16; i++) begin
      run_case($urandom % 4, $urandom % 6, 1'($urandom % 2));
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule